// File: doc/BRIEF.md
# Guarded External-Clock Timer

A 16-bit up-counter, loaded one byte at a time, that advances on every system clock (internal mode) or on each rising edge of an external clock pin (external mode). The pin is resampled through a two-stage synchronizer, and the edge is detected on the resampled signal. When the count wraps from all ones to zero, a sticky overflow flag is raised, and an interrupt output presents that flag gated by an enable.

An external edge that arrives close to a counter load, a timer enable or a change into external mode can raise a false overflow. To prevent this, the block opens a guard window whenever one of those events happens in external mode. While the window is open, a wrap still takes place in the count but cannot raise the flag. The window closes after two synchronized external rising edges followed by two system cycles. From then on, genuine wraps set the flag as usual.

Top module: `guarded_timer`

## Requirements
- R1: After reset the count is 0x0000 and both the flag and the interrupt output are 0.
- R2: A high-byte write replaces count bits 15:8 and a low-byte write replaces bits 7:0, leaving the other byte unchanged. The new value is visible after the next clock edge, and a write takes priority over a count advance in the same cycle.
- R3: With the mode input at 0 (internal) and enable at 1, the count increases by one on every clock edge and wraps modulo 65536.
- R4: With the mode input at 1 (external) and enable at 1, the count increases by one for each rising edge on the external pin. It becomes visible on the third clock edge after the pin is sampled high. With enable at 0 the count holds.
- R5: A wrap from 0xFFFF to 0x0000 caused by a counted advance sets the flag on the same edge that the count shows 0x0000, provided no guard window is open.
- R6: In external mode, a byte write, a rise of enable or a rise of the mode input opens the guard window. A wrap during the window, or in the cycle of the opening event, leaves the flag unchanged.
- R7: The window closes after two synchronized rising edges of the external pin, whether or not enable is set, followed by two system cycles. A wrap after that sets the flag.
- R8: A suppressed wrap still takes the count to 0x0000, and counting continues from there.
- R9: A clear strobe writes 0 to the flag. A flag set in the same cycle wins over the clear.
- R10: The interrupt output equals the flag ANDed with the interrupt enable input.
- R11: Writes and enable rises made in internal mode do not open the guard window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External count clock, asynchronous |
| wr_hi_i | input | 1 | Load strobe for count bits 15:8 |
| wr_lo_i | input | 1 | Load strobe for count bits 7:0 |
| wr_data_i | input | 8 | Byte to load |
| enable_i | input | 1 | Timer run enable |
| ext_mode_i | input | 1 | 1 = count external edges, 0 = count system clocks |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Writes 0 to the overflow flag |
| count_o | output | 16 | Current count |
| flag_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Loads and internal-mode advances appear one edge after the strobe or enable is sampled, so the bench drives on falling edges and reads the count on the next falling edge. An external pulse raised at a falling edge advances the count on the third rising edge after it. The pulse task therefore waits five falling edges before sampling, and it places a clear strobe exactly on the advance edge when set-over-clear priority is under test. The flag changes on the same edge as the wrap. The interrupt is combinational and is read one time step after its enable changes.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/gt_edge_sync.sv
module gt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], async_i};
    prev_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R4: a detected edge lasts exactly one cycle
  assert_single_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/gt_counter.sv
module gt_counter
  import gt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [DATA_W-1:0] data_i,
  output cnt_t              cnt_o,
  output logic              wrap_o
);
  cnt_t cnt_q, cnt_d;
  logic load;

  assign load = ld_hi_i | ld_lo_i;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      if (ld_hi_i) cnt_d[CNT_W-1:DATA_W] = data_i;
      if (ld_lo_i) cnt_d[DATA_W-1:0]     = data_i;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i & ~load & (&cnt_q);

  assert_load_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo_i |=> cnt_q[DATA_W-1:0] == $past(data_i));
  assert_load_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi_i |=> cnt_q[CNT_W-1:DATA_W] == $past(data_i));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load) |=> $stable(cnt_q));
  // R8: a wrap always lands on zero, suppressed or not
  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt_q == '0);
endmodule

// File: rtl/gt_guard.sv
module gt_guard #(
  parameter int EDGES = 2,
  parameter int TAIL  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic ext_rise_i,
  output logic active_o
);
  localparam int EW = $clog2(EDGES + 1);
  localparam int TW = $clog2(TAIL + 1);

  logic [EW-1:0] edges_q, edges_d;
  logic [TW-1:0] tail_q, tail_d;

  always_comb begin
    edges_d = edges_q;
    tail_d  = tail_q;
    if (arm_i) begin
      edges_d = EW'(EDGES);
      tail_d  = TW'(TAIL);
    end else begin
      if (ext_rise_i && edges_q != '0) edges_d = edges_q - 1'b1;
      if (edges_q == '0 && tail_q != '0) tail_d = tail_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges_q <= '0;
      tail_q  <= '0;
    end else begin
      edges_q <= edges_d;
      tail_q  <= tail_d;
    end
  end

  assign active_o = (edges_q != '0) | (tail_q != '0);

  assert_arm_opens_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> active_o);
  // R7: without edges or arming, an open edge phase stays open
  assert_edges_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm_i && !ext_rise_i && edges_q != '0) |=> edges_q == $past(edges_q));
endmodule

// File: rtl/guarded_timer.sv
module guarded_timer
  import gt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GUARD_EDGES = 2,
  parameter int GUARD_TAIL  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk_i,
  input  logic              wr_hi_i,
  input  logic              wr_lo_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              enable_i,
  input  logic              ext_mode_i,
  input  logic              irq_en_i,
  input  logic              flag_clr_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic ext_rise, tick, wrap, guard_active, arm, blank;
  logic en_q, mode_q, flag_q, flag_d;
  cnt_t cnt;

  gt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(ext_clk_i), .rise_o(ext_rise)
  );

  assign tick = enable_i & (ext_mode_i ? ext_rise : 1'b1);

  gt_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ld_hi_i(wr_hi_i),
    .ld_lo_i(wr_lo_i), .data_i(wr_data_i), .cnt_o(cnt), .wrap_o(wrap)
  );

  assign arm = ext_mode_i & (wr_hi_i | wr_lo_i | (enable_i & ~en_q) | ~mode_q);

  gt_guard #(.EDGES(GUARD_EDGES), .TAIL(GUARD_TAIL)) u_guard (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .ext_rise_i(ext_rise),
    .active_o(guard_active)
  );

  assign blank = guard_active | arm;

  always_comb begin
    flag_d = flag_q;
    if (wrap && !blank)   flag_d = 1'b1;
    else if (flag_clr_i)  flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      en_q   <= enable_i;
      mode_q <= ext_mode_i;
      flag_q <= flag_d;
    end
  end

  assign count_o = cnt;
  assign flag_o  = flag_q;
  assign irq_o   = flag_q & irq_en_i;

  assert_flag_on_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> cnt == '0);
  assert_blanked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> !$rose(flag_q));
  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !wrap) |=> !flag_q);
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !irq_o);
endmodule

// File: tb/guarded_timer_tb.sv
`timescale 1ns/1ps
module guarded_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ext_clk_i, wr_hi_i, wr_lo_i, enable_i, ext_mode_i, irq_en_i, flag_clr_i;
  logic [7:0]  wr_data_i;
  logic [15:0] count_o;
  logic        flag_o, irq_o;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  guarded_timer u_dut (
    .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i), .wr_hi_i(wr_hi_i),
    .wr_lo_i(wr_lo_i), .wr_data_i(wr_data_i), .enable_i(enable_i),
    .ext_mode_i(ext_mode_i), .irq_en_i(irq_en_i), .flag_clr_i(flag_clr_i),
    .count_o(count_o), .flag_o(flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input bit hi, input logic [7:0] d);
    @(negedge clk);
    wr_data_i = d;
    if (hi) wr_hi_i = 1'b1; else wr_lo_i = 1'b1;
    @(negedge clk);
    wr_hi_i = 1'b0;
    wr_lo_i = 1'b0;
  endtask

  task automatic load(input logic [15:0] v);
    wr_byte(1'b1, v[15:8]);
    wr_byte(1'b0, v[7:0]);
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr_i = 1'b1;
    @(negedge clk) flag_clr_i = 1'b0;
  endtask

  // pin high at a falling edge; the count moves on the third rising edge
  task automatic pulse(input bit clr_on_tick);
    @(negedge clk) ext_clk_i = 1'b1;
    @(negedge clk);
    @(negedge clk) begin ext_clk_i = 1'b0; flag_clr_i = clr_on_tick; end
    @(negedge clk) flag_clr_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] starts [4];
    rst_n = 1'b0; ext_clk_i = 0; wr_hi_i = 0; wr_lo_i = 0; wr_data_i = 0;
    enable_i = 0; ext_mode_i = 0; irq_en_i = 0; flag_clr_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", count_o, 16'h0000);
    chk("R1 flag", flag_o, 0);
    chk("R1 irq", irq_o, 0);

    wr_byte(1'b1, 8'hA5); chk("R2 hi byte", count_o, 16'hA500);
    wr_byte(1'b0, 8'h3C); chk("R2 lo byte", count_o, 16'hA53C);
    wr_byte(1'b1, 8'h12); chk("R2 hi keeps lo", count_o, 16'h123C);

    // load wins over an internal-mode advance
    @(negedge clk) begin enable_i = 1; wr_lo_i = 1; wr_data_i = 8'h77; end
    @(negedge clk) wr_lo_i = 0;
    chk("R2 load over tick", count_o, 16'h1277);
    @(negedge clk) enable_i = 0;
    chk("R2 count after load", count_o, 16'h1278);

    // R3 R5 R11: internal-mode sweep, expected value computed arithmetically
    starts[0] = 16'h0000; starts[1] = 16'h00FE; starts[2] = 16'h12FF; starts[3] = 16'hFFF9;
    for (int s = 0; s < 4; s++) begin
      for (int k = 1; k <= 8; k++) begin
        load(starts[s]);
        clear_flag();
        @(negedge clk) enable_i = 1;
        repeat (k) @(negedge clk);
        enable_i = 0;
        chk("R3 internal count", count_o, 16'((32'(starts[s]) + k) & 32'hFFFF));
        chk("R5 R11 internal wrap flag", flag_o, (32'(starts[s]) + k > 32'hFFFF) ? 1 : 0);
      end
    end

    // R10 with flag set by the last sweep run
    chk("R10 irq masked", irq_o, 0);
    irq_en_i = 1; #1;
    chk("R10 irq passes", irq_o, 1);
    clear_flag();
    chk("R9 clear", flag_o, 0);
    chk("R10 irq follows flag", irq_o, 0);

    // external mode
    @(negedge clk) ext_mode_i = 1;
    load(16'h0100);
    pulse(0); chk("R4 disabled holds", count_o, 16'h0100);
    @(negedge clk) enable_i = 1;
    pulse(0); chk("R4 edge counts", count_o, 16'h0101);
    pulse(0); chk("R4 second edge", count_o, 16'h0102);

    load(16'hFFFF);
    pulse(0);
    chk("R6 write blanks flag", flag_o, 0);
    chk("R8 suppressed wrap to zero", count_o, 16'h0000);
    pulse(0); chk("R8 counting continues", count_o, 16'h0001);

    load(16'hFFFD);
    pulse(0); pulse(0);
    chk("R7 count before close", count_o, 16'hFFFF);
    chk("R7 still clear", flag_o, 0);
    pulse(0);
    chk("R7 wrap after window", count_o, 16'h0000);
    chk("R7 flag after window", flag_o, 1);
    clear_flag();

    // enable rise opens the window; disabled edges close the old one
    @(negedge clk) enable_i = 0;
    load(16'hFFFF);
    pulse(0); pulse(0);
    chk("R7 disabled edges no count", count_o, 16'hFFFF);
    repeat (3) @(negedge clk);
    @(negedge clk) enable_i = 1;
    pulse(0);
    chk("R6 enable blanks count", count_o, 16'h0000);
    chk("R6 enable blanks flag", flag_o, 0);
    pulse(0);
    repeat (3) @(negedge clk);

    // switch into external mode opens the window
    @(negedge clk) begin enable_i = 0; ext_mode_i = 0; end
    load(16'hFFFE);
    @(negedge clk) enable_i = 1;
    @(negedge clk) ext_mode_i = 1;
    chk("R11 internal enable counts", count_o, 16'hFFFF);
    pulse(0);
    chk("R6 switch wrap count", count_o, 16'h0000);
    chk("R6 switch blanks flag", flag_o, 0);
    pulse(0);
    repeat (3) @(negedge clk);

    // set beats clear in the same cycle
    load(16'hFFFD);
    pulse(0); pulse(0);
    pulse(1);
    chk("R9 set over clear count", count_o, 16'h0000);
    chk("R9 set over clear flag", flag_o, 1);
    clear_flag();
    chk("R9 final clear", flag_o, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule